// File: doc/BRIEF.md
# Shared Bus Interconnect

This block is the central fabric of a pipelined shared bus with a parameterised number of masters and slaves. It takes bus requests from every master and decides which master owns the address phase. It routes that master's address and control to all slaves and raises one slave select from the top address bits. It returns the selected slave's read data, ready and response to the masters.

Address and data phases are pipelined. A registered copy of the owning master index and the decoded slave index follows the address phase one transfer behind. Write data is therefore taken from the master whose transfer is in its data phase, while a different master may already be driving the address bus. Ownership and the data-phase registers only move on cycles where the bus ready is high.

A slave may answer with an error, which reaches the master unchanged. A slave may also answer with a split response. In that case the master is removed from arbitration until that slave signals a release for it.

Top module: `shbus_fabric`

## Requirements
- R1: While `rst` is high, every output of the block is zero, whatever the inputs are.
- R2: When the owning master's transfer type is active (bit 1 set: NONSEQ `10` or SEQ `11`), `s_sel` is one-hot at the index equal to the binary value of the top ceil(log2(N_SLV)) address bits, so top bits `01` select slave 1. For IDLE `00` or BUSY `01`, `s_sel` is zero.
- R3: Arbitration is fixed priority, with master 0 highest. On a clock edge where `hready` is high, `m_grant` becomes one-hot at the lowest-numbered eligible requester, and `bus_owner` becomes that master's index.
- R4: When no master is eligible at an edge where `hready` is high, the default master (parameter `DEF_MST`, 0) is granted.
- R5: While `hready` is low, `m_grant`, `bus_owner` and the data-phase master and slave stay unchanged.
- R6: `s_addr`, `s_trans` and `s_write` are the address, transfer type and write flag of the master named by `bus_owner`, in the same cycle.
- R7: `s_wdata` is the write data of the master that owned the address phase at the last edge where `hready` was high. It lags `bus_owner` by one transfer.
- R8: `m_rdata`, `m_resp` and `hready` come from the slave decoded for the current data phase. When that data phase holds no active transfer, `hready` is 1 and `m_resp` is OKAY (`00`).
- R9: Response codes are OKAY `00`, ERROR `01`, RETRY `10` and SPLIT `11`. An error from the data-phase slave reaches `m_resp` in the same cycle. A response from any other slave does not.
- R10: A SPLIT response masks the data-phase master from arbitration. The mask holds until its slave sets bit `s*N_MST+m` of `s_unsplit`. The release clears the mask at that edge, and the master can win from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_req | input | N_MST | Bus request per master |
| m_addr | input | N_MST*AW | Address per master, master m at slice m |
| m_trans | input | N_MST*2 | Transfer type per master |
| m_write | input | N_MST | Write flag per master |
| m_wdata | input | N_MST*DW | Write data per master |
| s_rdata | input | N_SLV*DW | Read data per slave |
| s_ready | input | N_SLV | Ready per slave |
| s_resp | input | N_SLV*2 | Response per slave |
| s_unsplit | input | N_SLV*N_MST | Split release, slave s for master m at bit s*N_MST+m |
| m_grant | output | N_MST | One-hot grant |
| bus_owner | output | clog2(N_MST) | Index of the address-phase owner |
| hready | output | 1 | Bus ready to masters and slaves |
| m_rdata | output | DW | Read data to masters |
| m_resp | output | 2 | Response to masters |
| s_sel | output | N_SLV | One-hot slave select |
| s_addr | output | AW | Address to slaves |
| s_trans | output | 2 | Transfer type to slaves |
| s_write | output | 1 | Write flag to slaves |
| s_wdata | output | DW | Write data to slaves |

## Verification
The hardest situation to reach is the split sequence. A higher-priority master is masked while a lower one keeps winning, and the release and the re-entry land on successive edges. The bench holds ready low for one cycle with a SPLIT response, then raises ready and requests from both a masked and a lower-priority master. It then pulses a single release bit and watches ownership move edge by edge. Stalls and the address/data overlap across two masters are set up the same way, by steering the data-phase slave's ready while requests change.

// File: rtl/bus_pkg.sv
package bus_pkg;

    typedef enum logic [1:0] {
        RESP_OKAY  = 2'b00,
        RESP_ERROR = 2'b01,
        RESP_RETRY = 2'b10,
        RESP_SPLIT = 2'b11
    } resp_e;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    // width of an index over n items, never below one bit
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // a transfer type carries data when its upper bit is set
    function automatic logic trans_active(input logic [1:0] t);
        return t[1];
    endfunction

endpackage

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
    parameter int N_MST   = 3,
    parameter int DEF_MST = 0,
    localparam int MW     = bus_pkg::idx_w(N_MST)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_MST-1:0] req,
    input  logic [N_MST-1:0] mask,
    input  logic             advance,
    output logic [N_MST-1:0] grant,
    output logic [MW-1:0]    owner
);
    logic [N_MST-1:0] eligible;
    logic [MW-1:0]    pick;
    logic [N_MST-1:0] pick_oh;
    logic [N_MST-1:0] grant_q;
    logic [MW-1:0]    owner_q;

    assign eligible = req & ~mask;

    // lowest index wins; scan from the top so the last hit is the lowest
    always_comb begin
        pick = MW'(DEF_MST);
        for (int i = N_MST - 1; i >= 0; i--) begin
            if (eligible[i]) pick = MW'(i);
        end
    end

    always_comb begin
        pick_oh = '0;
        pick_oh[pick] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            grant_q[DEF_MST] <= 1'b1;
            owner_q <= MW'(DEF_MST);
        end else if (advance) begin
            grant_q <= pick_oh;
            owner_q <= pick;
        end
    end

    assign grant = grant_q;
    assign owner = owner_q;

    a_r5_hold_owner: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(owner_q) && $stable(grant_q));

    a_r3_top_priority: assert property (@(posedge clk) disable iff (rst)
        (advance && eligible[0]) |=> (owner_q == '0) && grant_q[0]);

    a_r4_default_master: assert property (@(posedge clk) disable iff (rst)
        (advance && (eligible == '0)) |=> (owner_q == MW'(DEF_MST)));

    a_r3_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(grant_q) == 1);

endmodule

// File: rtl/bus_split_track.sv
module bus_split_track #(
    parameter int N_MST = 3,
    parameter int N_SLV = 4,
    localparam int MW   = bus_pkg::idx_w(N_MST)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   split_hit,
    input  logic [MW-1:0]          split_mst,
    input  logic [N_SLV*N_MST-1:0] unsplit,
    output logic [N_MST-1:0]       mask_eff
);
    logic [N_MST-1:0] mask_q;
    logic [N_MST-1:0] set_vec;
    logic [N_MST-1:0] rel_vec;

    always_comb begin
        rel_vec = '0;
        for (int s = 0; s < N_SLV; s++) begin
            rel_vec = rel_vec | unsplit[s*N_MST +: N_MST];
        end
    end

    always_comb begin
        set_vec = '0;
        if (split_hit) set_vec[split_mst] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= (mask_q & ~rel_vec) | set_vec;
    end

    // a split seen this cycle already keeps the master out of this edge's decision
    assign mask_eff = mask_q | set_vec;

    a_r10_split_sets_mask: assert property (@(posedge clk) disable iff (rst)
        split_hit |=> mask_q[$past(split_mst)]);

    a_r10_mask_needs_release: assert property (@(posedge clk) disable iff (rst)
        (mask_q != '0 && rel_vec == '0) |=> ((mask_q & $past(mask_q)) == $past(mask_q)));

endmodule

// File: rtl/bus_decoder.sv
module bus_decoder #(
    parameter int N_SLV = 4,
    localparam int SW   = bus_pkg::idx_w(N_SLV)
) (
    input  logic [SW-1:0]    top_bits,
    input  logic             active,
    output logic [N_SLV-1:0] sel,
    output logic [SW-1:0]    idx,
    output logic             hit
);
    assign idx = top_bits;
    assign hit = active && (int'(top_bits) < N_SLV);

    always_comb begin
        sel = '0;
        for (int s = 0; s < N_SLV; s++) begin
            if (hit && (int'(top_bits) == s)) sel[s] = 1'b1;
        end
    end
endmodule

// File: rtl/shbus_fabric.sv
module shbus_fabric #(
    parameter int N_MST   = 3,
    parameter int N_SLV   = 4,
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int DEF_MST = 0
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [N_MST-1:0]                    m_req,
    input  logic [N_MST*AW-1:0]                 m_addr,
    input  logic [N_MST*2-1:0]                  m_trans,
    input  logic [N_MST-1:0]                    m_write,
    input  logic [N_MST*DW-1:0]                 m_wdata,
    input  logic [N_SLV*DW-1:0]                 s_rdata,
    input  logic [N_SLV-1:0]                    s_ready,
    input  logic [N_SLV*2-1:0]                  s_resp,
    input  logic [N_SLV*N_MST-1:0]              s_unsplit,
    output logic [N_MST-1:0]                    m_grant,
    output logic [bus_pkg::idx_w(N_MST)-1:0]    bus_owner,
    output logic                                hready,
    output logic [DW-1:0]                       m_rdata,
    output logic [1:0]                          m_resp,
    output logic [N_SLV-1:0]                    s_sel,
    output logic [AW-1:0]                       s_addr,
    output logic [1:0]                          s_trans,
    output logic                                s_write,
    output logic [DW-1:0]                       s_wdata
);
    import bus_pkg::*;

    localparam int MW = idx_w(N_MST);
    localparam int SW = idx_w(N_SLV);

    typedef struct packed {
        logic          active;
        logic [SW-1:0] slv;
        logic [MW-1:0] mst;
    } dphase_t;

    logic [AW-1:0] ma_arr [N_MST];
    logic [1:0]    mt_arr [N_MST];
    logic [DW-1:0] mw_arr [N_MST];
    logic [DW-1:0] rd_arr [N_SLV];
    logic [1:0]    rs_arr [N_SLV];

    for (genvar g = 0; g < N_MST; g++) begin : g_mst
        assign ma_arr[g] = m_addr[g*AW +: AW];
        assign mt_arr[g] = m_trans[g*2 +: 2];
        assign mw_arr[g] = m_wdata[g*DW +: DW];
    end

    for (genvar g = 0; g < N_SLV; g++) begin : g_slv
        assign rd_arr[g] = s_rdata[g*DW +: DW];
        assign rs_arr[g] = s_resp[g*2 +: 2];
    end

    logic [N_MST-1:0] grant_i;
    logic [MW-1:0]    owner_i;
    logic [N_MST-1:0] mask_i;
    logic             ready_i;
    logic [1:0]       resp_i;
    logic             split_hit;
    logic [AW-1:0]    a_addr;
    logic [1:0]       a_trans;
    logic             a_write;
    logic [N_SLV-1:0] sel_i;
    logic [SW-1:0]    dec_idx;
    logic             dec_hit;
    dphase_t          dp_q;

    // address-phase multiplexer, driven by the current owner
    assign a_addr  = ma_arr[owner_i];
    assign a_trans = mt_arr[owner_i];
    assign a_write = m_write[owner_i];

    bus_decoder #(.N_SLV(N_SLV)) u_dec (
        .top_bits (a_addr[AW-1 -: SW]),
        .active   (trans_active(a_trans)),
        .sel      (sel_i),
        .idx      (dec_idx),
        .hit      (dec_hit)
    );

    bus_arbiter #(.N_MST(N_MST), .DEF_MST(DEF_MST)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (m_req),
        .mask    (mask_i),
        .advance (ready_i),
        .grant   (grant_i),
        .owner   (owner_i)
    );

    // data-phase register: one transfer behind the address phase
    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q <= '0;
        end else if (ready_i) begin
            dp_q.active <= dec_hit;
            dp_q.slv    <= dec_idx;
            dp_q.mst    <= owner_i;
        end
    end

    // return path from the data-phase slave
    assign ready_i   = dp_q.active ? s_ready[dp_q.slv] : 1'b1;
    assign resp_i    = dp_q.active ? rs_arr[dp_q.slv] : RESP_OKAY;
    assign split_hit = dp_q.active && (resp_i == RESP_SPLIT);

    bus_split_track #(.N_MST(N_MST), .N_SLV(N_SLV)) u_split (
        .clk       (clk),
        .rst       (rst),
        .split_hit (split_hit),
        .split_mst (dp_q.mst),
        .unsplit   (s_unsplit),
        .mask_eff  (mask_i)
    );

    // all outputs forced low during reset
    assign m_grant   = rst ? '0   : grant_i;
    assign bus_owner = rst ? '0   : owner_i;
    assign hready    = rst ? 1'b0 : ready_i;
    assign m_rdata   = rst ? '0   : rd_arr[dp_q.slv];
    assign m_resp    = rst ? '0   : resp_i;
    assign s_sel     = rst ? '0   : sel_i;
    assign s_addr    = rst ? '0   : a_addr;
    assign s_trans   = rst ? '0   : a_trans;
    assign s_write   = rst ? 1'b0 : a_write;
    assign s_wdata   = rst ? '0   : mw_arr[dp_q.mst];

    a_r2_single_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_i));

    a_r7_dp_follows_owner: assert property (@(posedge clk) disable iff (rst)
        ready_i |=> (dp_q.mst == $past(owner_i)));

    a_r5_dp_held: assert property (@(posedge clk) disable iff (rst)
        !ready_i |=> $stable(dp_q));

    a_r8_idle_dp_ready: assert property (@(posedge clk) disable iff (rst)
        (ready_i && !dec_hit) |=> hready && (m_resp == RESP_OKAY));

endmodule

// File: tb/test_shbus_fabric.sv
`timescale 1ns/1ps
module test_shbus_fabric;
    localparam int NM = 3;
    localparam int NS = 4;
    localparam int AW = 16;
    localparam int DW = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic [NM-1:0]     m_req;
    logic [NM*AW-1:0]  m_addr;
    logic [NM*2-1:0]   m_trans;
    logic [NM-1:0]     m_write;
    logic [NM*DW-1:0]  m_wdata;
    logic [NS*DW-1:0]  s_rdata;
    logic [NS-1:0]     s_ready;
    logic [NS*2-1:0]   s_resp;
    logic [NS*NM-1:0]  s_unsplit;
    logic [NM-1:0]     m_grant;
    logic [1:0]        bus_owner;
    logic              hready;
    logic [DW-1:0]     m_rdata;
    logic [1:0]        m_resp;
    logic [NS-1:0]     s_sel;
    logic [AW-1:0]     s_addr;
    logic [1:0]        s_trans;
    logic              s_write;
    logic [DW-1:0]     s_wdata;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 0;

    shbus_fabric #(.N_MST(NM), .N_SLV(NS), .AW(AW), .DW(DW), .DEF_MST(0)) i_shbus_fabric (
        .clk(clk), .rst(rst), .m_req(m_req), .m_addr(m_addr), .m_trans(m_trans),
        .m_write(m_write), .m_wdata(m_wdata), .s_rdata(s_rdata), .s_ready(s_ready),
        .s_resp(s_resp), .s_unsplit(s_unsplit), .m_grant(m_grant), .bus_owner(bus_owner),
        .hready(hready), .m_rdata(m_rdata), .m_resp(m_resp), .s_sel(s_sel),
        .s_addr(s_addr), .s_trans(s_trans), .s_write(s_write), .s_wdata(s_wdata)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [AW-1:0] maddr(input int m, input int top);
        return {2'(top), 14'(16'h0040 + m)};
    endfunction

    task automatic set_addr(input int m, input int top);
        m_addr[m*AW +: AW] = maddr(m, top);
    endtask

    task automatic check_owner(input string tag, input int exp);
        check(bus_owner == 2'(exp), tag, 32'(bus_owner), 32'(exp));
        check(m_grant == 3'(1 << exp), tag, 32'(m_grant), 32'(1 << exp));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        m_req     = '1;
        m_trans   = {NM{2'b10}};
        m_write   = 3'b101;
        s_ready   = '1;
        s_resp    = '0;
        s_unsplit = '0;
        for (int m = 0; m < NM; m++) begin
            set_addr(m, m);
            m_wdata[m*DW +: DW] = 16'h5000 + 16'(m);
        end
        for (int s = 0; s < NS; s++) s_rdata[s*DW +: DW] = 16'hA000 + 16'(s);

        // R1: outputs zero during reset
        tick();
        tick();
        check({m_grant, bus_owner, hready, m_resp, s_sel, s_trans, s_write} == '0, "R1 ctrl",
              32'({m_grant, bus_owner, hready, m_resp, s_sel, s_trans, s_write}), 0);
        check(s_addr == '0 && s_wdata == '0 && m_rdata == '0, "R1 data",
              {s_addr, s_wdata}, 0);

        rst = 1'b0;
        // R3: priority sweep over every request pattern
        for (int r = 7; r >= 1; r--) begin
            m_req = 3'(r);
            tick();
            begin
                int e;
                e = (r & 1) ? 0 : ((r & 2) ? 1 : 2);
                check_owner("R3 priority", e);
            end
        end

        // R4: default master after master 2 owned the bus
        m_req = 3'b100;
        tick();
        check_owner("R3 sole req", 2);
        m_req = 3'b000;
        tick();
        check_owner("R4 default", 0);

        // R2 / R6: decode sweep on master 0
        m_req = 3'b001;
        tick();
        for (int t = 0; t < NS; t++) begin
            set_addr(0, t);
            #1;
            check(s_sel == 4'(1 << t), "R2 decode", 32'(s_sel), 32'(1 << t));
            check(s_addr == maddr(0, t), "R6 addr", 32'(s_addr), 32'(maddr(0, t)));
        end
        m_trans[1:0] = 2'b00;
        #1;
        check(s_sel == '0, "R2 idle", 32'(s_sel), 0);
        m_trans[1:0] = 2'b01;
        #1;
        check(s_sel == '0 && s_trans == 2'b01, "R2 busy", 32'({s_sel, s_trans}), 1);
        m_trans[1:0] = 2'b10;
        set_addr(0, 0);

        // R6: control from master 2
        m_req = 3'b100;
        tick();
        check(s_addr == maddr(2, 2) && s_write == 1'b1, "R6 owner2",
              32'({s_write, s_addr}), 32'({1'b1, maddr(2, 2)}));

        // R7 / R8: overlap of address and data phases across masters
        m_req = 3'b001;
        tick();
        tick();
        m_req = 3'b010;
        tick();
        check_owner("R3 switch", 1);
        check(s_addr == maddr(1, 1), "R6 new owner", 32'(s_addr), 32'(maddr(1, 1)));
        check(s_wdata == 16'h5000, "R7 wdata lag", 32'(s_wdata), 32'h5000);
        check(m_rdata == 16'hA000, "R8 rdata slv0", 32'(m_rdata), 32'hA000);
        tick();
        check(s_wdata == 16'h5001, "R7 wdata next", 32'(s_wdata), 32'h5001);
        check(m_rdata == 16'hA001, "R8 rdata slv1", 32'(m_rdata), 32'hA001);

        // R5: stall holds ownership and data phase
        s_ready = 4'b0000;
        m_req   = 3'b001;
        tick();
        check(hready == 1'b0, "R8 ready low", 32'(hready), 0);
        check_owner("R5 hold", 1);
        tick();
        check_owner("R5 hold2", 1);
        check(s_wdata == 16'h5001, "R5 dp held", 32'(s_wdata), 32'h5001);
        s_ready = 4'b1111;
        tick();
        check_owner("R5 release", 0);

        // R8: idle data phase reports ready and OKAY
        m_trans[1:0] = 2'b00;
        tick();
        s_ready = 4'b0000;
        s_resp  = {NS{2'b01}};
        #1;
        check(hready == 1'b1 && m_resp == 2'b00, "R8 idle dp", 32'({hready, m_resp}), 32'h4);
        s_ready = 4'b1111;
        s_resp  = '0;
        m_trans[1:0] = 2'b10;
        tick();

        // R9: error passes from the data-phase slave only
        m_req = 3'b010;
        tick();
        tick();
        s_resp[3*2 +: 2] = 2'b01;
        #1;
        check(m_resp == 2'b00, "R9 other slave", 32'(m_resp), 0);
        s_resp[1*2 +: 2] = 2'b01;
        #1;
        check(m_resp == 2'b01, "R9 error", 32'(m_resp), 1);
        s_resp = '0;

        // R10: split masks master 1 until released
        s_resp[1*2 +: 2] = 2'b11;
        s_ready[1] = 1'b0;
        m_req = 3'b110;
        tick();
        check_owner("R10 split stall", 1);
        s_ready = 4'b1111;
        tick();
        check_owner("R10 masked", 2);
        s_resp = '0;
        tick();
        tick();
        check_owner("R10 still masked", 2);
        s_unsplit[1*NM + 1] = 1'b1;
        tick();
        check_owner("R10 release edge", 2);
        s_unsplit = '0;
        tick();
        check_owner("R10 re-entry", 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule